// File: doc/BRIEF.md
# Vector add-and-scale accelerator

This block is a fixed-function compute engine that a host processor or a coordinating controller drives through a small byte-wide register window. The window exposes a status byte and three 64-bit argument registers. The first two arguments give the byte addresses of two input arrays in local scratchpad memory, and the third gives the byte address of an output array. A controller writes the three arguments and then writes the start code into the status byte. The engine reads both arrays, forms four times the element-wise sum of each pair and writes the results back. When it is finished it raises an interrupt.

The array memories sit outside the block. Each array offers two word accesses per clock. The engine fills eight parallel lanes in steps of two words per array, computes all eight lanes in one cycle and drains the results two words per cycle. A 16-element invocation therefore runs as two batches of eight. The interrupt is a level. It stays high until software writes 0 to the status byte, and only then does the block accept a new start.

Top module: `vecscale_acc`

## Requirements
- R1: After a synchronous reset the status byte reads 0, every argument byte reads 0, `irq` is low, and neither `mem_rd_en` nor `y_wr_en` is asserted.
- R2: The status byte is at window offset 0. Code 0 means idle, 1 means start requested and 4 means busy. Writing 1 while idle makes the status read 1 for exactly one cycle and then 4.
- R3: The argument registers hold 8 bytes each, stored little-endian at window offsets 1 (array A), 9 (array B) and 17 (array Y). Every byte reads back as written. Only the low `AW` bits of each argument are used as the byte address of its array.
- R4: Writes to the argument bytes take effect only while the status is idle. At any other time they leave the stored value unchanged.
- R5: For i = 0..N-1 the engine writes Y[i] = (A[i] + B[i]) << 2, truncated to 32 bits. Element i of every array is at byte address base + 4*i.
- R6: Scratchpad traffic: `mem_rd_en` presents two A and two B word addresses per cycle, and read data is expected one cycle later. `y_wr_en` writes two words per cycle. Reads and writes are never asserted in the same cycle. Each invocation writes exactly N words, all inside the 64-byte Y array.
- R7: `irq` rises after the last result write has been presented. While it is high the status reads 4. It stays high until a status write of 0, and it is low in the cycle after that write.
- R8: Status writes are ignored in three cases: any write while the start is pending or the block is busy (including 0), any write other than 1 while idle, and any write other than 0 after completion.
- R9: After a completed invocation has been cleared, a new start runs a correct new invocation with new arguments.
- R10: Window offsets above 24 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register window byte write strobe |
| reg_addr | input | RAW (5) | Register window byte offset, used for both reads and writes |
| reg_wdata | input | 8 | Byte written to the window |
| reg_rdata | output | 8 | Registered byte at the offset presented in the previous cycle |
| irq | output | 1 | Completion interrupt, a level signal |
| mem_rd_en | output | 1 | Read strobe for the A and B arrays |
| a_rd_addr | output | PORTS*AW (24) | Two byte addresses into array A, port p at bits [p*AW +: AW] |
| b_rd_addr | output | PORTS*AW (24) | Two byte addresses into array B |
| a_rd_data | input | PORTS*DW (64) | A words returned one cycle after the read strobe |
| b_rd_data | input | PORTS*DW (64) | B words returned one cycle after the read strobe |
| y_wr_en | output | 1 | Write strobe for array Y |
| y_wr_addr | output | PORTS*AW (24) | Two byte addresses into array Y |
| y_wr_data | output | PORTS*DW (64) | Two result words |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16 elements, 8 lanes, 2 ports per array and a 12-bit scratchpad address. With these values each invocation runs two batches of four load steps and four store steps, so the batch rollover and the address step between batches are both exercised. The 12-bit address width is narrower than the 64-bit arguments, so random upper argument bytes test that they are ignored. Directed operands that overflow 32 bits test the modulo wrap of the shifted sum.

// File: rtl/vecscale_pkg.sv
package vecscale_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_LOAD,
    ST_DRAIN,
    ST_CALC,
    ST_STORE,
    ST_FIN,
    ST_DONE
  } seq_state_t;

  localparam logic [7:0] STAT_IDLE = 8'h00;
  localparam logic [7:0] STAT_GO   = 8'h01;
  localparam logic [7:0] STAT_BUSY = 8'h04;

endpackage

// File: rtl/vecscale_regs.sv
module vecscale_regs #(
  parameter int RAW = 5,
  parameter int AW  = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [RAW-1:0] addr,
  input  logic [7:0]     wdata,
  input  logic [7:0]     status,
  input  logic           args_open,
  output logic           stat_wr,
  output logic [7:0]     stat_wdata,
  output logic [7:0]     rdata,
  output logic [AW-1:0]  base_a,
  output logic [AW-1:0]  base_b,
  output logic [AW-1:0]  base_y
);

  localparam int NARGS     = 3;
  localparam int ARG_BYTES = 8;
  localparam int ARG_BASE  = 1;

  logic [ARG_BYTES*8-1:0] args_q [NARGS];
  logic [7:0]             rd_byte;

  assign stat_wr    = wr && (addr == '0);
  assign stat_wdata = wdata;
  assign base_a     = args_q[0][AW-1:0];
  assign base_b     = args_q[1][AW-1:0];
  assign base_y     = args_q[2][AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NARGS; k++) args_q[k] <= '0;
    end else if (wr && args_open) begin
      for (int k = 0; k < NARGS; k++)
        for (int j = 0; j < ARG_BYTES; j++)
          if (addr == RAW'(ARG_BASE + ARG_BYTES*k + j))
            args_q[k][8*j +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (addr == '0) rd_byte = status;
    for (int k = 0; k < NARGS; k++)
      for (int j = 0; j < ARG_BYTES; j++)
        if (addr == RAW'(ARG_BASE + ARG_BYTES*k + j))
          rd_byte = args_q[k][8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_byte;
  end

  // R4
  args_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !args_open |=> $stable({args_q[0], args_q[1], args_q[2]}));

endmodule

// File: rtl/vecscale_lanes.sv
module vecscale_lanes #(
  parameter int DW    = 32,
  parameter int LANES = 8,
  parameter int PORTS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic [((LANES/PORTS) > 1 ? $clog2(LANES/PORTS) : 1)-1:0] cap_slot,
  input  logic [PORTS*DW-1:0] rd_a,
  input  logic [PORTS*DW-1:0] rd_b,
  input  logic                calc_en,
  input  logic                st_en,
  input  logic [((LANES/PORTS) > 1 ? $clog2(LANES/PORTS) : 1)-1:0] st_slot,
  output logic [PORTS*DW-1:0] wr_data
);

  localparam int STEPS = LANES / PORTS;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [LANES*DW-1:0] res_flat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SLOT = g / PORTS;
    localparam int PIDX = g % PORTS;
    logic [DW-1:0] a_q, b_q, r_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        a_q <= '0;
        b_q <= '0;
        r_q <= '0;
      end else begin
        if (cap_en && cap_slot == SW'(SLOT)) begin
          a_q <= rd_a[PIDX*DW +: DW];
          b_q <= rd_b[PIDX*DW +: DW];
        end
        if (calc_en) r_q <= (a_q + b_q) << 2;
      end
    end

    assign res_flat[g*DW +: DW] = r_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data <= '0;
    end else if (st_en) begin
      for (int p = 0; p < PORTS; p++)
        wr_data[p*DW +: DW] <= res_flat[(int'(st_slot)*PORTS + p)*DW +: DW];
    end
  end

  // R6
  cap_calc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cap_en && st_en));

endmodule

// File: rtl/vecscale_ctrl.sv
module vecscale_ctrl
  import vecscale_pkg::*;
#(
  parameter int DW    = 32,
  parameter int N     = 16,
  parameter int LANES = 8,
  parameter int PORTS = 2,
  parameter int AW    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stat_wr,
  input  logic [7:0]          stat_wdata,
  input  logic [AW-1:0]       base_a,
  input  logic [AW-1:0]       base_b,
  input  logic [AW-1:0]       base_y,
  output logic [7:0]          status,
  output logic                args_open,
  output logic                irq,
  output logic                rd_en,
  output logic [PORTS*AW-1:0] rd_addr_a,
  output logic [PORTS*AW-1:0] rd_addr_b,
  output logic                cap_en,
  output logic [((LANES/PORTS) > 1 ? $clog2(LANES/PORTS) : 1)-1:0] cap_slot,
  output logic                calc_en,
  output logic                st_en,
  output logic [((LANES/PORTS) > 1 ? $clog2(LANES/PORTS) : 1)-1:0] st_slot,
  output logic                wr_en,
  output logic [PORTS*AW-1:0] wr_addr
);

  localparam int STEPS   = LANES / PORTS;
  localparam int BATCHES = N / LANES;
  localparam int SW      = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int BW      = (BATCHES > 1) ? $clog2(BATCHES) : 1;
  localparam int EB      = DW / 8;

  seq_state_t    state_q;
  logic [SW-1:0] step_q, slot_o_q, slot_d_q;
  logic [BW-1:0] batch_q;
  logic          rd_vld_q;

  always_comb begin
    case (state_q)
      ST_IDLE: status = STAT_IDLE;
      ST_ARM:  status = STAT_GO;
      default: status = STAT_BUSY;
    endcase
  end

  assign args_open = (state_q == ST_IDLE);
  assign cap_en    = rd_vld_q;
  assign cap_slot  = slot_d_q;
  assign calc_en   = (state_q == ST_CALC);
  assign st_en     = (state_q == ST_STORE);
  assign st_slot   = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      batch_q   <= '0;
      slot_o_q  <= '0;
      slot_d_q  <= '0;
      rd_vld_q  <= 1'b0;
      rd_en     <= 1'b0;
      wr_en     <= 1'b0;
      irq       <= 1'b0;
      rd_addr_a <= '0;
      rd_addr_b <= '0;
      wr_addr   <= '0;
    end else begin
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      rd_vld_q <= rd_en;
      slot_d_q <= slot_o_q;
      case (state_q)
        ST_IDLE: if (stat_wr && stat_wdata == STAT_GO) state_q <= ST_ARM;
        ST_ARM: begin
          state_q <= ST_LOAD;
          step_q  <= '0;
          batch_q <= '0;
        end
        ST_LOAD: begin
          rd_en    <= 1'b1;
          slot_o_q <= step_q;
          for (int p = 0; p < PORTS; p++) begin
            rd_addr_a[p*AW +: AW] <= base_a +
              AW'((int'(batch_q)*LANES + int'(step_q)*PORTS + p) * EB);
            rd_addr_b[p*AW +: AW] <= base_b +
              AW'((int'(batch_q)*LANES + int'(step_q)*PORTS + p) * EB);
          end
          if (step_q == SW'(STEPS-1)) begin
            step_q  <= '0;
            state_q <= ST_DRAIN;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DRAIN: if (rd_vld_q && slot_d_q == SW'(STEPS-1)) state_q <= ST_CALC;
        ST_CALC:  state_q <= ST_STORE;
        ST_STORE: begin
          wr_en <= 1'b1;
          for (int p = 0; p < PORTS; p++)
            wr_addr[p*AW +: AW] <= base_y +
              AW'((int'(batch_q)*LANES + int'(step_q)*PORTS + p) * EB);
          if (step_q == SW'(STEPS-1)) begin
            step_q <= '0;
            if (batch_q == BW'(BATCHES-1)) begin
              state_q <= ST_FIN;
            end else begin
              batch_q <= batch_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_FIN: begin
          irq     <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: if (stat_wr && stat_wdata == STAT_IDLE) begin
          irq     <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  arm_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (status == STAT_GO) |=> (status == STAT_BUSY));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(stat_wr && stat_wdata == STAT_IDLE)) |=> irq);

  // R7
  irq_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status == STAT_BUSY));

  // R6
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (status == STAT_BUSY && !irq) |=> (status == STAT_BUSY));

endmodule

// File: rtl/vecscale_acc.sv
module vecscale_acc #(
  parameter int DW    = 32,
  parameter int N     = 16,
  parameter int LANES = 8,
  parameter int PORTS = 2,
  parameter int AW    = 12,
  parameter int RAW   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [RAW-1:0]      reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                irq,
  output logic                mem_rd_en,
  output logic [PORTS*AW-1:0] a_rd_addr,
  output logic [PORTS*AW-1:0] b_rd_addr,
  input  logic [PORTS*DW-1:0] a_rd_data,
  input  logic [PORTS*DW-1:0] b_rd_data,
  output logic                y_wr_en,
  output logic [PORTS*AW-1:0] y_wr_addr,
  output logic [PORTS*DW-1:0] y_wr_data
);

  localparam int STEPS = LANES / PORTS;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic          stat_wr, args_open, cap_en, calc_en, st_en;
  logic [7:0]    stat_wdata, status;
  logic [AW-1:0] base_a, base_b, base_y;
  logic [SW-1:0] cap_slot, st_slot;

  vecscale_regs #(.RAW(RAW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .args_open(args_open), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .rdata(reg_rdata),
    .base_a(base_a), .base_b(base_b), .base_y(base_y)
  );

  vecscale_ctrl #(.DW(DW), .N(N), .LANES(LANES), .PORTS(PORTS), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .base_a(base_a), .base_b(base_b), .base_y(base_y),
    .status(status), .args_open(args_open), .irq(irq),
    .rd_en(mem_rd_en), .rd_addr_a(a_rd_addr), .rd_addr_b(b_rd_addr),
    .cap_en(cap_en), .cap_slot(cap_slot), .calc_en(calc_en),
    .st_en(st_en), .st_slot(st_slot), .wr_en(y_wr_en), .wr_addr(y_wr_addr)
  );

  vecscale_lanes #(.DW(DW), .LANES(LANES), .PORTS(PORTS)) u_lanes (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_slot(cap_slot),
    .rd_a(a_rd_data), .rd_b(b_rd_data), .calc_en(calc_en),
    .st_en(st_en), .st_slot(st_slot), .wr_data(y_wr_data)
  );

endmodule

// File: tb/sim_vecscale_acc.sv
`timescale 1ns/1ps
module sim_vecscale_acc;

  localparam int DW = 32, N = 16, LANES = 8, PORTS = 2, AW = 12, RAW = 5;
  localparam int WORDS = 1 << (AW - 2);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                reg_wr = 1'b0;
  logic [RAW-1:0]      reg_addr = '0;
  logic [7:0]          reg_wdata = '0;
  logic [7:0]          reg_rdata;
  logic                irq, mem_rd_en, y_wr_en;
  logic [PORTS*AW-1:0] a_rd_addr, b_rd_addr, y_wr_addr;
  logic [PORTS*DW-1:0] a_rd_data = '0, b_rd_data = '0, y_wr_data;

  logic [DW-1:0] mem [WORDS];
  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, oob_cnt = 0, both_cnt = 0;
  int ybase = 0;
  logic [DW-1:0] va [N];
  logic [DW-1:0] vb [N];

  always #2.5 clk = ~clk;

  vecscale_acc #(.DW(DW), .N(N), .LANES(LANES), .PORTS(PORTS), .AW(AW), .RAW(RAW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_rd_en(mem_rd_en), .a_rd_addr(a_rd_addr), .b_rd_addr(b_rd_addr),
    .a_rd_data(a_rd_data), .b_rd_data(b_rd_data), .y_wr_en(y_wr_en),
    .y_wr_addr(y_wr_addr), .y_wr_data(y_wr_data)
  );

  // scratchpad model: one-cycle read latency, two words per array per cycle
  always @(posedge clk) begin
    if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    if (mem_rd_en && y_wr_en) both_cnt <= both_cnt + 1;
    for (int p = 0; p < PORTS; p++) begin
      if (mem_rd_en) begin
        a_rd_data[p*DW +: DW] <= mem[int'(a_rd_addr[p*AW +: AW]) / 4];
        b_rd_data[p*DW +: DW] <= mem[int'(b_rd_addr[p*AW +: AW]) / 4];
      end
    end
    if (y_wr_en) begin
      wr_cnt <= wr_cnt + PORTS;
      for (int p = 0; p < PORTS; p++) begin
        mem[int'(y_wr_addr[p*AW +: AW]) / 4] <= y_wr_data[p*DW +: DW];
        if (int'(y_wr_addr[p*AW +: AW]) < ybase || int'(y_wr_addr[p*AW +: AW]) >= ybase + 4*N)
          oob_cnt <= oob_cnt + 1;
      end
    end
  end

  function automatic logic [DW-1:0] expect_y(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] s;
    s = a + b;
    return {s[DW-3:0], 2'b00};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic reg_write(input int off, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RAW'(off); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int off, output logic [7:0] d);
    @(negedge clk);
    reg_addr = RAW'(off);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic write_arg(input int idx, input logic [63:0] v);
    for (int j = 0; j < 8; j++) reg_write(1 + 8*idx + j, v[8*j +: 8]);
  endtask

  task automatic read_arg(input int idx, output logic [63:0] v);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) begin
      reg_read(1 + 8*idx + j, b);
      v[8*j +: 8] = b;
    end
  endtask

  task automatic run_case(input int n, input bit directed);
    int abase, bbase, rd0, wr0, wait_cyc;
    logic [63:0] arg_a, arg_b, arg_y, rb;
    logic [7:0] s;
    abase = int'($urandom % 16) * 64;
    bbase = 1024 + int'($urandom % 16) * 64;
    ybase = 2048 + int'($urandom % 16) * 64;
    for (int i = 0; i < N; i++) begin
      if (directed) begin
        va[i] = (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h4000_0000 + DW'(i);
        vb[i] = (i % 2 == 1) ? 32'h0000_0001 : 32'h0000_0003;
      end else begin
        va[i] = $urandom;
        vb[i] = $urandom;
      end
      mem[abase/4 + i] = va[i];
      mem[bbase/4 + i] = vb[i];
      mem[ybase/4 + i] = 32'hDEAD_BEEF;
    end
    arg_a = {$urandom, 20'h0, 12'(abase)};
    arg_b = {$urandom, 20'h0, 12'(bbase)};
    arg_y = {$urandom, 20'h0, 12'(ybase)};
    write_arg(0, arg_a);
    write_arg(1, arg_b);
    write_arg(2, arg_y);
    read_arg(0, rb); check(rb == arg_a, "R3 arg A readback", rb, arg_a);
    read_arg(2, rb); check(rb == arg_y, "R3 arg Y readback", rb, arg_y);
    rd0 = rd_cnt; wr0 = wr_cnt;
    reg_addr = '0;
    reg_write(0, 8'h01);
    @(negedge clk); check(reg_rdata == 8'h01, "R2 start code visible", reg_rdata, 8'h01);
    @(negedge clk); check(reg_rdata == 8'h04, "R2 busy code", reg_rdata, 8'h04);
    // R8 / R4: writes while busy are ignored
    reg_write(0, 8'h00);
    reg_write(1, ~arg_a[7:0]);
    reg_read(0, s); check(s == 8'h04, "R8 status write ignored while busy", s, 8'h04);
    wait_cyc = 0;
    while (!irq && wait_cyc < 200) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(irq == 1'b1, "R7 irq raised", irq, 1);
    check(wr_cnt - wr0 == N, "R6 write count", wr_cnt - wr0, N);
    check(rd_cnt - rd0 == N / PORTS, "R6 read cycles", rd_cnt - rd0, N / PORTS);
    for (int i = 0; i < N; i++)
      check(mem[ybase/4 + i] == expect_y(va[i], vb[i]), $sformatf("R5 case %0d elem %0d", n, i),
            mem[ybase/4 + i], expect_y(va[i], vb[i]));
    reg_read(0, s); check(s == 8'h04, "R7 status busy while irq", s, 8'h04);
    reg_write(0, 8'h02);
    reg_read(0, s);
    check(s == 8'h04 && irq, "R8 non-zero write after done ignored", {s, 7'h0, irq}, {8'h04, 8'h01});
    reg_write(0, 8'h00);
    check(irq == 1'b0, "R7 irq cleared by status 0", irq, 0);
    reg_read(0, s); check(s == 8'h00, "R7 status idle after clear", s, 0);
    read_arg(0, rb); check(rb == arg_a, "R4 arg write while busy ignored", rb, arg_a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] s;
    int rd0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(irq == 1'b0 && mem_rd_en == 1'b0 && y_wr_en == 1'b0, "R1 outputs idle",
          {irq, mem_rd_en, y_wr_en}, 0);
    reg_read(0, s);  check(s == 8'h00, "R1 status zero", s, 0);
    reg_read(17, s); check(s == 8'h00, "R1 arg byte zero", s, 0);
    // R8: non-start write in idle
    rd0 = rd_cnt;
    reg_write(0, 8'h05);
    repeat (10) @(negedge clk);
    reg_read(0, s);
    check(s == 8'h00 && rd_cnt == rd0, "R8 idle non-start write ignored", {s, 24'(rd_cnt - rd0)}, 0);
    // R10 offsets beyond the window
    write_arg(2, 64'h0123_4567_89AB_CDEF);
    reg_read(30, s); check(s == 8'h00, "R10 unmapped offset", s, 0);
    reg_read(24, s); check(s == 8'h01, "R3 arg Y top byte", s, 8'h01);
    // R5 directed wrap case, then R9 repeated random invocations
    run_case(0, 1'b1);
    for (int n = 1; n < 6; n++) run_case(n, 1'b0);
    check(oob_cnt == 0, "R6 writes inside Y array", oob_cnt, 0);
    check(both_cnt == 0, "R6 reads and writes exclusive", both_cnt, 0);
    summary();
  end

endmodule